// File: doc/BRIEF.md
# Four-Lane Float/Integer Converter

This block converts a 128-bit vector, split into four independent 32-bit lanes, between IEEE-754 single precision and 32-bit integers. A 2-bit opcode, shared by all lanes of a beat, picks the direction and the signedness. Each lane's result is written back to the same bit positions it was read from, so the output vector is the input vector reinterpreted in place.

Integer to float rounds to nearest, with ties going to even. Float to integer truncates toward zero. Out-of-range float inputs saturate to the bounds of the target type. NaN produces zero. Denormal float inputs are flushed to zero. Any out-of-range or NaN conversion sets an invalid flag, and the flag stays set until reset.

The unit is a two-stage pipeline. It accepts a beat on every cycle that the valid strobe is high. Each beat carries its own opcode through the pipeline, so beats with different opcodes can follow one another without gaps.

Top module: `vcvt4_unit`

## Requirements
- R1: Opcode encoding is 00 signed-to-float, 01 unsigned-to-float, 10 float-to-signed and 11 float-to-unsigned. One opcode applies to all four lanes of a beat. Lane k occupies bits 32k+31 down to 32k at both input and output, and no lane affects another.
- R2: Signed-to-float rounds to nearest with ties to even. Examples: 1 gives 0x3F800000, -1 gives 0xBF800000 and 0 gives 0x00000000. 0x80000000 gives 0xCF000000, 0x01000001 gives 0x4B800000, 0x01000003 gives 0x4B800002 and 0x7FFFFFFF gives 0x4F000000.
- R3: Unsigned-to-float rounds to nearest with ties to even. Examples: 0xFFFFFFFF gives 0x4F800000, 0x80000000 gives 0x4F000000 and 3 gives 0x40400000.
- R4: Float-to-integer truncates toward zero. Any input whose magnitude is below 1.0, including zeros and denormals, gives 0 and does not set the invalid flag. Examples: 1.5 gives 1, -1.5 gives 0xFFFFFFFF and 100.75 gives 100.
- R5: Float-to-signed saturates. Values at or above 2^31, including +infinity, give 0x7FFFFFFF and set the invalid flag. Values below -2^31, including -infinity, give 0x80000000 and set the invalid flag. Exactly -2^31 gives 0x80000000 without setting the flag.
- R6: Float-to-unsigned saturates. Values at or above 2^32 give 0xFFFFFFFF and set the invalid flag. Every negative input gives 0. A negative input sets the invalid flag only when its magnitude is at least 1.0. Example: 0x4F7FFFFF gives 0xFFFFFF00.
- R7: A NaN input to either float-to-integer opcode gives 0 and sets the invalid flag.
- R8: The invalid flag rises in the same cycle as the result of the offending beat. It then stays high until reset. Integer-to-float beats never set it.
- R9: out_valid is high exactly two cycles after in_valid was high, with the matching result on out_data. A new beat can be accepted on every cycle.
- R10: While reset is active and after it is released, out_valid, out_data and the invalid flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat strobe |
| in_op | input | 2 | Conversion opcode for the beat |
| in_data | input | 128 | Four 32-bit input lanes |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_data | output | 128 | Four 32-bit result lanes |
| invalid_flag | output | 1 | Sticky invalid-conversion flag |

## Verification
Two things can happen in the same cycle: a new beat is captured while the previous beat's result is presented, and the two beats may carry different opcodes. The bench provokes this by streaming beats back to back with all four opcodes interleaved and one bubble in the stream. It judges every cycle: out_valid must match the strobe from two cycles earlier, and each result must match the conversion chosen by its own beat's opcode. A second overlap is between a saturating beat raising the flag and the next, clean beat. The bench checks that the clean beat leaves the flag high.

// File: rtl/vcvt_pkg.sv
package vcvt_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned EXP_W  = 8;
   localparam int unsigned FRAC_W = 23;
   localparam int unsigned BIAS   = 127;

   typedef enum logic [1:0] {
      OP_S2F = 2'b00,
      OP_U2F = 2'b01,
      OP_F2S = 2'b10,
      OP_F2U = 2'b11
   } cvt_op_e;
endpackage

// File: rtl/vcvt_f2i.sv
module vcvt_f2i
   import vcvt_pkg::*;
(
   input  logic [WORD_W-1:0] fin,
   input  logic              to_unsigned,
   output logic [WORD_W-1:0] res,
   output logic              bad
);
   localparam logic [EXP_W-1:0] E_ONE   = EXP_W'(BIAS);
   localparam logic [EXP_W-1:0] E_EXACT = EXP_W'(BIAS + FRAC_W);
   localparam logic [EXP_W-1:0] E_S_TOP = EXP_W'(BIAS + WORD_W - 1);
   localparam logic [EXP_W-1:0] E_U_TOP = EXP_W'(BIAS + WORD_W);

   logic                 sgn;
   logic [EXP_W-1:0]     ex;
   logic [FRAC_W-1:0]    fr;
   logic [EXP_W-1:0]     sh;
   logic [WORD_W-1:0]    sig;
   logic [WORD_W-1:0]    mag;

   always_comb begin
      sgn = fin[WORD_W-1];
      ex  = fin[WORD_W-2 -: EXP_W];
      fr  = fin[FRAC_W-1:0];
      sig = {{(WORD_W-FRAC_W-1){1'b0}}, 1'b1, fr};
      sh  = '0;
      mag = '0;
      res = '0;
      bad = 1'b0;
      if (ex >= E_EXACT) begin
         sh  = ex - E_EXACT;
         mag = sig << sh;
      end else begin
         sh  = E_EXACT - ex;
         mag = sig >> sh;
      end
      if (ex == '1 && fr != '0) begin
         bad = 1'b1;
      end else if (ex < E_ONE) begin
         res = '0;
      end else if (to_unsigned) begin
         if (sgn) begin
            bad = 1'b1;
         end else if (ex >= E_U_TOP) begin
            res = '1;
            bad = 1'b1;
         end else begin
            res = mag;
         end
      end else if (!sgn) begin
         if (ex >= E_S_TOP) begin
            res = {1'b0, {(WORD_W-1){1'b1}}};
            bad = 1'b1;
         end else begin
            res = mag;
         end
      end else if (ex > E_S_TOP || (ex == E_S_TOP && fr != '0)) begin
         res = {1'b1, {(WORD_W-1){1'b0}}};
         bad = 1'b1;
      end else begin
         res = -mag;
      end
   end
endmodule

// File: rtl/vcvt_i2f.sv
module vcvt_i2f
   import vcvt_pkg::*;
(
   input  logic [WORD_W-1:0] iin,
   input  logic              is_unsigned,
   output logic [WORD_W-1:0] res
);
   localparam int unsigned LEAD_W = $clog2(WORD_W);
   localparam int unsigned KEEP_W = FRAC_W + 1;
   localparam int unsigned DROP_W = WORD_W - KEEP_W;

   logic                 neg;
   logic [WORD_W-1:0]    mag;
   logic [LEAD_W-1:0]    lead;
   logic [WORD_W-1:0]    norm;
   logic [KEEP_W-1:0]    keep;
   logic                 grd;
   logic                 stk;
   logic                 up;
   logic [KEEP_W:0]      sum;
   logic [EXP_W-1:0]     expo;
   logic [FRAC_W-1:0]    mant;

   always_comb begin
      neg  = !is_unsigned && iin[WORD_W-1];
      mag  = neg ? -iin : iin;
      lead = '0;
      for (int k = 0; k < WORD_W; k++) begin
         if (mag[k]) lead = LEAD_W'(k);
      end
      norm = mag << (LEAD_W'(WORD_W-1) - lead);
      keep = norm[WORD_W-1 -: KEEP_W];
      grd  = norm[DROP_W-1];
      stk  = |norm[DROP_W-2:0];
      up   = grd & (stk | keep[0]);
      sum  = {1'b0, keep} + (KEEP_W+1)'(up);
      expo = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(sum[KEEP_W]);
      mant = sum[KEEP_W] ? sum[KEEP_W-1:1] : sum[FRAC_W-1:0];
      res  = (mag == '0) ? '0 : {neg, expo, mant};
   end
endmodule

// File: rtl/vcvt4_unit.sv
module vcvt4_unit
   import vcvt_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              in_op,
   input  logic [LANES*LANE_W-1:0] in_data,
   output logic                    out_valid,
   output logic [LANES*LANE_W-1:0] out_data,
   output logic                    invalid_flag
);
   localparam int unsigned VEC_W = LANES * LANE_W;

   if (LANE_W != WORD_W) begin : g_bad_width
      $error("vcvt4_unit: LANE_W must equal the single-precision word width");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("vcvt4_unit: LANES must be at least one");
   end

   logic             s1_v;
   cvt_op_e          s1_op;
   logic [VEC_W-1:0] s1_d;
   logic [VEC_W-1:0] lane_res;
   logic [LANES-1:0] lane_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         s1_op <= OP_S2F;
         s1_d  <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_op <= cvt_op_e'(in_op);
            s1_d  <= in_data;
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] f2i_res;
      logic [LANE_W-1:0] i2f_res;
      logic              f2i_bad;

      vcvt_f2i u_f2i (
         .fin         (s1_d[g*LANE_W +: LANE_W]),
         .to_unsigned (s1_op[0]),
         .res         (f2i_res),
         .bad         (f2i_bad)
      );
      vcvt_i2f u_i2f (
         .iin         (s1_d[g*LANE_W +: LANE_W]),
         .is_unsigned (s1_op[0]),
         .res         (i2f_res)
      );
      assign lane_res[g*LANE_W +: LANE_W] = s1_op[1] ? f2i_res : i2f_res;
      assign lane_bad[g] = s1_op[1] & f2i_bad;

      assert_neg_unsigned_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_v && s1_op == OP_F2U && s1_d[g*LANE_W + LANE_W-1])
         |=> out_data[g*LANE_W +: LANE_W] == '0);

      assert_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (s1_v && s1_op[1] && s1_d[g*LANE_W + LANE_W-2 -: EXP_W] == '1
          && s1_d[g*LANE_W +: FRAC_W] != '0)
         |=> (out_data[g*LANE_W +: LANE_W] == '0 && invalid_flag));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_data     <= '0;
         invalid_flag <= 1'b0;
      end else begin
         out_valid <= s1_v;
         if (s1_v) begin
            out_data <= lane_res;
            if (|lane_bad) invalid_flag <= 1'b1;
         end
      end
   end

   assert_valid_two_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   assert_idle_two_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_flag |=> invalid_flag);

   assert_int_src_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!invalid_flag && !(s1_v && s1_op[1])) |=> !invalid_flag);
endmodule

// File: tb/test_vcvt4_unit.sv
module test_vcvt4_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_op = 2'b00;
   logic [127:0] in_data = '0;
   logic         out_valid;
   logic [127:0] out_data;
   logic         invalid_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vcvt4_unit i_vcvt4_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_op        (in_op),
      .in_data      (in_data),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .invalid_flag (invalid_flag)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one beat: drive, then sample two cycles later
   task automatic one(input logic [1:0] op, input logic [127:0] d,
                      input logic [127:0] e, input logic ef, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_data = d;
      @(negedge clk);
      in_valid = 1'b0; in_data = '0;
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === e, tag, out_data, e);
      chk(invalid_flag === ef, {tag, " flag"}, 128'(invalid_flag), 128'(ef));
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b0 && out_data === '0 && invalid_flag === 1'b0,
          "R10 reset state", {out_valid, invalid_flag, out_data[125:0]}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R10 idle after reset", 128'(out_valid), '0);
   endtask

   task automatic t_s2f();
      do_reset();
      one(2'b00, {32'h00000001, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
                 {32'h3F800000, 32'hBF800000, 32'h00000000, 32'hCF000000}, 1'b0,
                 "R2 signed exact and min");
      one(2'b00, {32'h01000001, 32'h01000003, 32'h7FFFFFFF, 32'h00000064},
                 {32'h4B800000, 32'h4B800002, 32'h4F000000, 32'h42C80000}, 1'b0,
                 "R2 signed ties to even");
   endtask

   task automatic t_u2f();
      do_reset();
      one(2'b01, {32'hFFFFFFFF, 32'h80000000, 32'h00000003, 32'h01000001},
                 {32'h4F800000, 32'h4F000000, 32'h40400000, 32'h4B800000}, 1'b0,
                 "R3 unsigned rounding");
   endtask

   task automatic t_f2s();
      do_reset();
      one(2'b10, {32'h3FC00000, 32'hBFC00000, 32'h42C98000, 32'h00000001},
                 {32'h00000001, 32'hFFFFFFFF, 32'h00000064, 32'h00000000}, 1'b0,
                 "R4 truncation toward zero");
      one(2'b10, {32'h3F000000, 32'hBF7FFFFF, 32'hCF000000, 32'h80000000},
                 {32'h00000000, 32'h00000000, 32'h80000000, 32'h00000000}, 1'b0,
                 "R5 exact min and small values no flag");
      one(2'b10, {32'h4F000000, 32'hCF000001, 32'h7F800000, 32'hFF800000},
                 {32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'h80000000}, 1'b1,
                 "R5 signed saturation");
   endtask

   task automatic t_f2u();
      do_reset();
      one(2'b11, {32'h4F7FFFFF, 32'h4F000000, 32'hBF000000, 32'h3FC00000},
                 {32'hFFFFFF00, 32'h80000000, 32'h00000000, 32'h00000001}, 1'b0,
                 "R6 unsigned in range and small negative");
      one(2'b11, {32'h00000000, 32'hBF800000, 32'h00000000, 32'h00000000},
                 {32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000}, 1'b1,
                 "R6 negative one flags");
      do_reset();
      one(2'b11, {32'h4F800000, 32'h3F800000, 32'h00000000, 32'h00000000},
                 {32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000000}, 1'b1,
                 "R6 unsigned saturation");
   endtask

   task automatic t_nan_sticky();
      do_reset();
      one(2'b10, {32'h7FC00000, 32'h3F800000, 32'hFFFFFFFF, 32'h40000000},
                 {32'h00000000, 32'h00000001, 32'h00000000, 32'h00000002}, 1'b1,
                 "R7 NaN gives zero");
      one(2'b01, {32'h00000001, 32'h00000000, 32'h00000000, 32'h00000002},
                 {32'h3F800000, 32'h00000000, 32'h00000000, 32'h40000000}, 1'b1,
                 "R8 flag stays high");
      do_reset();
      @(negedge clk);
      chk(invalid_flag === 1'b0, "R8 reset clears flag", 128'(invalid_flag), '0);
      one(2'b11, {32'h7FC00001, 32'h00000000, 32'h00000000, 32'h00000000},
                 '0, 1'b1, "R7 NaN unsigned");
      do_reset();
      one(2'b00, {32'h7FC00000, 32'hFFFFFFFF, 32'h80000000, 32'h7F800000},
                 {32'h4EFF8000, 32'hBF800000, 32'hCF000000, 32'h4EFF0000}, 1'b0,
                 "R8 int source never flags");
   endtask

   // back-to-back beats with interleaved opcodes and one bubble
   task automatic t_stream();
      logic [1:0]   ops[6];
      logic [127:0] din[6];
      logic [127:0] dexp[6];
      logic         vld[6];
      ops[0] = 2'b00; din[0] = {4{32'h00000002}}; dexp[0] = {4{32'h40000000}}; vld[0] = 1;
      ops[1] = 2'b10; din[1] = {4{32'h40400000}}; dexp[1] = {4{32'h00000003}}; vld[1] = 1;
      ops[2] = 2'b01; din[2] = {4{32'hFFFFFFFF}}; dexp[2] = {4{32'h4F800000}}; vld[2] = 1;
      ops[3] = 2'b11; din[3] = '0;                dexp[3] = '0;                vld[3] = 0;
      ops[4] = 2'b11; din[4] = {4{32'h41200000}}; dexp[4] = {4{32'h0000000A}}; vld[4] = 1;
      ops[5] = 2'b00; din[5] = {4{32'hFFFFFFFE}}; dexp[5] = {4{32'hC0000000}}; vld[5] = 1;
      do_reset();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            chk(out_valid === vld[i-2], "R9 strobe latency",
                128'(out_valid), 128'(vld[i-2]));
            if (vld[i-2])
               chk(out_data === dexp[i-2], "R1 R9 per-beat opcode",
                   out_data, dexp[i-2]);
         end
         if (i < 6) begin
            in_valid = vld[i]; in_op = ops[i]; in_data = din[i];
         end else begin
            in_valid = 1'b0; in_data = '0;
         end
      end
      chk(invalid_flag === 1'b0, "R8 clean stream no flag", 128'(invalid_flag), '0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_s2f();
      t_u2f();
      t_f2s();
      t_f2u();
      t_nan_sticky();
      t_stream();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule